// File: doc/BRIEF.md
# Distributed ID-Based Bus Arbiter

This block selects one bus owner out of several contenders without any central priority encoder. When a start pulse arrives, each contender that has a request drives its identification number onto a set of shared lines. Those lines resolve as a logical OR of every driver. A contender watches the resolved lines. If it finds a position where the lines carry 1 while its own identifier carries 0, it stops driving that bit and every less significant bit. It drives its full identifier again once no such position remains. The process repeats once per clock, and the pattern on the lines converges to the largest identifier among the requesters.

Requests and identifiers are captured only at the start pulse. After a fixed number of clocks the round is declared done. The contender whose identifier equals the resolved code then receives a one-hot grant, which holds until the next start pulse. The electrical open-collector behaviour is modelled as a plain OR. Whatever transfer follows the grant lies outside this block.

Top module: `dist_id_arbiter`

## Requirements
- R1: While reset is asserted, code_o is 0, grant_o is all zeros and done_o is 0.
- R2: On the clock edge that samples start_i high, every requesting contender begins driving its full identifier. Just after that edge, code_o equals the bitwise OR of the identifiers of all requesting contenders.
- R3: On each following edge of the round, a contender stops driving the highest bit position p where code_o is 1 and its identifier is 0, and every position below p. It keeps driving the positions above p. With identifiers 5 and 6 requesting, code_o reads 4'b0111 after the start edge and 4'b0110 one edge later.
- R4: done_o is 0 after the start edge and after each of the next ID_W-1 edges. It becomes 1 on the ID_W-th edge after the start edge.
- R5: While done_o is 1, code_o equals the largest identifier among the contenders that requested at the start edge.
- R6: While done_o is 1, grant_o has exactly bit i set, where contender i requested and its identifier equals code_o. grant_o is all zeros whenever done_o is 0. Requesters are assumed to carry distinct identifiers.
- R7: A round started with no request ends with done_o at 1, code_o at 0 and grant_o all zeros.
- R8: Changes to req_i or id_i after the start edge have no effect on the round in progress. They are used only at the next start pulse.
- R9: A start pulse during a round or after it restarts arbitration, and done_o is 0 just after that edge.
- R10: While done_o is 1 and no new start pulse arrives, code_o and grant_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle pulse that opens an arbitration round |
| req_i | input | N_CONT | Request bit per contender, sampled at the start pulse |
| id_i | input | N_CONT*ID_W | Identifier of contender k in bits [k*ID_W +: ID_W] |
| code_o | output | ID_W | Resolved OR of the shared arbitration lines |
| grant_o | output | N_CONT | One-hot grant, valid while done_o is 1 |
| done_o | output | 1 | Round has settled |

## Verification
The bench sweeps every request subset against many sets of distinct identifiers, including sets that contain identifier 0 and sets where the largest requester has low-order ones under a loser's high-order ones, such as 1001 against 0110. A withdrawal that sticks permanently would leave 1000 on the lines in that case and grant nobody. A rule that also withdraws where the lines show 0 would deadlock in the same way. It also checks the exact edge on which done_o rises, because a counter off by one would grant from a code that is not yet stable. Late request changes and restarts during and after a round are probed as well: a design that samples requests continuously would switch winners mid-round.

// File: rtl/darb_pkg.sv
package darb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RESOLVE = 2'd1,
    PH_DONE    = 2'd2
  } darb_phase_e;

endpackage

// File: rtl/arb_contender.sv
module arb_contender #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic            req_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] lines_i,
  output logic [ID_W-1:0] drive_o,
  output logic            hit_o
);

  logic            req_q;
  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] drive_q;

  // Bits kept: those above the highest position where lines=1 and own bit=0.
  function automatic logic [ID_W-1:0] keep_mask(input logic [ID_W-1:0] lines,
                                                input logic [ID_W-1:0] own);
    logic [ID_W-1:0] m;
    logic            lost;
    lost = 1'b0;
    for (int b = ID_W - 1; b >= 0; b--) begin
      if (!lost && lines[b] && !own[b]) begin
        lost = 1'b1;
      end
      m[b] = !lost;
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      id_q    <= '0;
      drive_q <= '0;
    end else if (load_i) begin
      req_q   <= req_i;
      id_q    <= id_i;
      drive_q <= req_i ? id_i : '0;
    end else if (step_i) begin
      drive_q <= req_q ? (id_q & keep_mask(lines_i, id_q)) : '0;
    end
  end

  assign drive_o = drive_q;
  assign hit_o   = req_q && (id_q == lines_i);

endmodule

// File: rtl/arb_wired_or.sv
module arb_wired_or #(
  parameter int N_CONT = 4,
  parameter int ID_W   = 4
) (
  input  logic [N_CONT*ID_W-1:0] drives_i,
  output logic [ID_W-1:0]        lines_o
);

  always_comb begin
    lines_o = '0;
    for (int k = 0; k < N_CONT; k++) begin
      lines_o = lines_o | drives_i[k*ID_W +: ID_W];
    end
  end

endmodule

// File: rtl/arb_sequencer.sv
module arb_sequencer
  import darb_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic step_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(ID_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ID_W - 1);

  darb_phase_e      phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign step_o = (phase_q == PH_RESOLVE) && !start_i;
  assign done_o = (phase_q == PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_RESOLVE;
      cnt_q   <= '0;
    end else if (step_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_STEP) begin
        phase_q <= PH_DONE;
      end
    end
  end

endmodule

// File: rtl/dist_id_arbiter.sv
module dist_id_arbiter #(
  parameter int N_CONT = 4,
  parameter int ID_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [N_CONT-1:0]      req_i,
  input  logic [N_CONT*ID_W-1:0] id_i,
  output logic [ID_W-1:0]        code_o,
  output logic [N_CONT-1:0]      grant_o,
  output logic                   done_o
);

  logic [N_CONT*ID_W-1:0] drive_w;
  logic [ID_W-1:0]        lines_w;
  logic [N_CONT-1:0]      hit_w;
  logic                   step_w;
  logic                   done_w;

  arb_sequencer #(.ID_W(ID_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .step_o (step_w),
    .done_o (done_w)
  );

  for (genvar k = 0; k < N_CONT; k++) begin : g_cont
    arb_contender #(.ID_W(ID_W)) u_cont (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_i),
      .step_i (step_w),
      .req_i  (req_i[k]),
      .id_i   (id_i[k*ID_W +: ID_W]),
      .lines_i(lines_w),
      .drive_o(drive_w[k*ID_W +: ID_W]),
      .hit_o  (hit_w[k])
    );
  end

  arb_wired_or #(.N_CONT(N_CONT), .ID_W(ID_W)) u_or (
    .drives_i(drive_w),
    .lines_o (lines_w)
  );

  assign code_o  = lines_w;
  assign done_o  = done_w;
  assign grant_o = done_w ? hit_w : '0;

endmodule

// File: rtl/dist_id_arbiter_chk.sv
module dist_id_arbiter_chk #(
  parameter int N_CONT = 4,
  parameter int ID_W   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [N_CONT-1:0]      req_i,
  input logic [N_CONT*ID_W-1:0] id_i,
  input logic [ID_W-1:0]        code_o,
  input logic [N_CONT-1:0]      grant_o,
  input logic                   done_o,
  input logic                   step_w
);

  localparam int SW = $clog2(ID_W + 2) + 1;
  localparam logic [SW-1:0] SETTLE = SW'(ID_W + 1);

  logic [ID_W-1:0] or_now, max_now, max_q;
  logic            dup_now, any_q, seen_q;
  logic [SW-1:0]   since_q;

  always_comb begin
    or_now  = '0;
    max_now = '0;
    dup_now = 1'b0;
    for (int a = 0; a < N_CONT; a++) begin
      if (req_i[a]) begin
        or_now = or_now | id_i[a*ID_W +: ID_W];
        if (id_i[a*ID_W +: ID_W] > max_now) max_now = id_i[a*ID_W +: ID_W];
        for (int b = a + 1; b < N_CONT; b++) begin
          if (req_i[b] && id_i[a*ID_W +: ID_W] == id_i[b*ID_W +: ID_W]) dup_now = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      any_q   <= 1'b0;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else if (start_i) begin
      max_q   <= max_now;
      any_q   <= |req_i;
      seen_q  <= 1'b1;
      since_q <= SW'(1);
    end else if (seen_q && since_q != SETTLE) begin
      since_q <= since_q + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (code_o == '0 && grant_o == '0 && !done_o);
    end
  end

  assert_first_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> code_o == $past(or_now));

  assert_done_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> done_o == (since_q == SETTLE));

  assert_idle_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !done_o);

  assert_step_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |-> !done_o);

  assert_winner_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> code_o == max_q);

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> done_o);

  assert_grant_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && any_q) |-> $countones(grant_o) == 1);

  assert_unique_ids_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !dup_now);

  assert_empty_round_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !any_q) |-> (grant_o == '0 && code_o == '0));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(code_o) && $stable(grant_o)));

endmodule

bind dist_id_arbiter dist_id_arbiter_chk #(.N_CONT(N_CONT), .ID_W(ID_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .req_i  (req_i),
  .id_i   (id_i),
  .code_o (code_o),
  .grant_o(grant_o),
  .done_o (done_o),
  .step_w (step_w)
);

// File: tb/dist_id_arbiter_bench.sv
`timescale 1ns/1ps
module dist_id_arbiter_bench;
  localparam int N = 4;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [N-1:0]   req_i;
  logic [N*W-1:0] id_i;
  logic [W-1:0]   code_o;
  logic [N-1:0]   grant_o;
  logic           done_o;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  dist_id_arbiter #(.N_CONT(N), .ID_W(W)) u_dist_id_arbiter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .id_i(id_i), .code_o(code_o), .grant_o(grant_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] or_of(input logic [N-1:0] r, input logic [N*W-1:0] ids);
    logic [W-1:0] v = '0;
    for (int k = 0; k < N; k++) if (r[k]) v = v | ids[k*W +: W];
    return v;
  endfunction

  function automatic logic [W-1:0] max_of(input logic [N-1:0] r, input logic [N*W-1:0] ids);
    int best = 0;
    for (int k = 0; k < N; k++) if (r[k] && int'(ids[k*W +: W]) > best) best = int'(ids[k*W +: W]);
    return W'(best);
  endfunction

  function automatic logic [N-1:0] grant_of(input logic [N-1:0] r, input logic [N*W-1:0] ids);
    logic [N-1:0] g = '0;
    logic [W-1:0] m = max_of(r, ids);
    for (int k = 0; k < N; k++) if (r[k] && ids[k*W +: W] == m) g[k] = 1'b1;
    return g;
  endfunction

  task automatic start_round(input logic [N-1:0] r, input logic [N*W-1:0] ids);
    @(negedge clk);
    start_i = 1'b1;
    req_i   = r;
    id_i    = ids;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [N*W-1:0] ids;
    rst_n = 1'b0; start_i = 1'b0; req_i = '0; id_i = '0;
    repeat (3) @(negedge clk);
    check(code_o == 0 && grant_o == 0 && !done_o, "R1 reset state",
          {code_o, grant_o, 3'b0, done_o}, 0);
    rst_n = 1'b1;

    // R3: identifiers 5 and 6 requesting
    ids = '0; ids[0*W +: W] = 4'd5; ids[1*W +: W] = 4'd6;
    start_round(4'b0011, ids);
    check(code_o == 4'b0111, "R2 first code 5|6", code_o, 4'b0111);
    @(negedge clk);
    check(code_o == 4'b0110, "R3 withdrawal of 5", code_o, 4'b0110);
    repeat (2) @(negedge clk);
    check(!done_o, "R4 not done before settle", done_o, 0);
    @(negedge clk);
    check(done_o, "R4 done at settle", done_o, 1);
    check(code_o == 4'd6, "R5 winner 6", code_o, 6);
    check(grant_o == 4'b0010, "R6 grant to contender 1", grant_o, 4'b0010);
    repeat (2) @(negedge clk);
    check(code_o == 4'd6 && grant_o == 4'b0010, "R10 hold while done",
          {code_o, grant_o}, {4'd6, 4'b0010});

    // R9 restart from done, then R8 late changes
    ids = '0; ids[2*W +: W] = 4'd9;
    start_round(4'b0100, ids);
    check(!done_o, "R9 restart clears done", done_o, 0);
    check(code_o == 4'd9, "R2 code single requester", code_o, 9);
    req_i = 4'b1111; id_i = {4'd15, 4'd14, 4'd13, 4'd12};
    repeat (4) @(negedge clk);
    check(done_o && code_o == 4'd9, "R8 late requests ignored (code)", code_o, 9);
    check(grant_o == 4'b0100, "R8 late requests ignored (grant)", grant_o, 4'b0100);

    // R9 restart mid-round
    ids = {4'd1, 4'd2, 4'd3, 4'd4};
    start_round(4'b1111, ids);
    @(negedge clk);
    start_round(4'b0001, ids);
    check(!done_o && code_o == 4'd4, "R9 restart mid-round", {done_o, code_o}, {1'b0, 4'd4});
    repeat (4) @(negedge clk);
    check(done_o && grant_o == 4'b0001, "R9 restarted round result", grant_o, 4'b0001);

    // R7: nobody requests
    start_round(4'b0000, {4'd15, 4'd14, 4'd13, 4'd12});
    repeat (4) @(negedge clk);
    check(done_o && code_o == 0 && grant_o == 0, "R7 empty round",
          {done_o, code_o, grant_o}, {1'b1, 4'd0, 4'd0});

    // Sweep: all request subsets over many distinct identifier sets
    for (int base = 0; base < 16; base++) begin
      for (int step = 1; step < 16; step += 2) begin
        for (int k = 0; k < N; k++) ids[k*W +: W] = W'(base + k * step);
        for (int m = 0; m < 16; m++) begin
          start_round(N'(m), ids);
          check(code_o == or_of(N'(m), ids), "R2 sweep first code", code_o, or_of(N'(m), ids));
          repeat (3) @(negedge clk);
          check(!done_o, "R4 sweep early done", done_o, 0);
          @(negedge clk);
          check(done_o, "R4 sweep done", done_o, 1);
          check(code_o == max_of(N'(m), ids), "R5 sweep winner", code_o, max_of(N'(m), ids));
          check(grant_o == grant_of(N'(m), ids), "R6 sweep grant", grant_o, grant_of(N'(m), ids));
        end
      end
    end

    summary();
  end

endmodule